// File: doc/BRIEF.md
# Binary XNOR-Popcount Accumulate-Threshold Datapath

This block is the arithmetic core of a binary neural network layer engine. A register keeps one stationary vector of input-channel bits, where a stored 1 stands for +1 and a stored 0 for -1. Every accepted weight word is combined with that vector bit by bit through XNOR gates. A balanced adder tree then counts the agreeing bits over the active input channels. The count is added into the accumulator of one output channel. Successive weight words address output channels 0, 1, 2 and so on, and the sequence wraps after the last active channel. This gives one output channel per cycle, so a full square product over all channels takes as many cycles as there are channels.

Accumulators live in a single-port-read, single-port-write RAM, and each entry has a live flag. A clear strobe drops all live flags at once, so the whole bank reads as zero without any sweep through the RAM. Once accumulation is done, a stream of small thresholds is applied, one per output channel in channel order. Each threshold is shifted left by a configurable amount, and the matching accumulator is compared against it. The result bits are gathered into one output word, which is presented on a valid/ready stream. An outer sequencer supplies the words and the strobes and does all memory addressing and loop control.

Top module: `bnn_xnor_core`

## Requirements
- R1: For each accepted weight word, the count of bit positions where the weight equals the stored input bit (XNOR = 1) is added to the accumulator of the current output channel.
- R2: An input word is stored on each cycle with `in_valid` high. A weight accepted in that same cycle still uses the previously stored input word. `in_ready` is always 1.
- R3: Only channels 0 to `cfg_in_ch`-1 contribute to the count. Higher bit positions add nothing, whatever their values.
- R4: Accepted weight words address output channels 0, 1, ..., `cfg_out_ch`-1 in turn, then wrap back to channel 0.
- R5: A cycle with `acc_clr` high, together with the cycle after it, accepts no weight (`w_ready` low). All accumulators then read as zero and the next weight addresses channel 0. Words accepted before the strobe are not counted after it.
- R6: Accumulators saturate at 2^ACC_W-1 and never wrap.
- R7: The effective threshold is the THR_W-bit threshold shifted left by min(`cfg_shift`, ACC_W-THR_W). Shift codes above that limit act as the limit.
- R8: Output bit k is 0 when accumulator k is less than the effective threshold k, and 1 otherwise. Bits at and above `cfg_out_ch` are 0.
- R9: Thresholds are applied in channel order. After `cfg_out_ch` of them, `out_valid` rises. `out_valid` and `out_data` then stay stable until `out_ready` is seen, and no threshold is accepted meanwhile. After the handshake `out_valid` is 0.
- R10: Weight words may arrive back to back in every cycle, including repeated hits on one channel when `cfg_out_ch` is 1, and each word is still counted exactly once.
- R11: After reset `out_valid` is 0, `out_data` is 0, and `in_ready`, `w_ready` and `thr_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_ch | input | CNT_W | Active input channels (1..CH) |
| cfg_out_ch | input | CNT_W | Active output channels (1..CH) |
| cfg_shift | input | SH_W | Threshold left-shift code |
| in_valid | input | 1 | Input vector strobe |
| in_ready | output | 1 | Input vector accepted (always 1) |
| in_data | input | CH | Input feature bits, one per channel |
| w_valid | input | 1 | Weight word valid |
| w_ready | output | 1 | Weight word accepted |
| w_data | input | CH | Weight bits for the current output channel |
| acc_clr | input | 1 | Clear all accumulators and the channel pointer |
| thr_valid | input | 1 | Threshold valid |
| thr_ready | output | 1 | Threshold accepted |
| thr_data | input | THR_W | Unshifted threshold for the next output channel |
| out_valid | output | 1 | Binarized output word valid |
| out_ready | input | 1 | Output word taken |
| out_data | output | CH | Binarized output bits, bit k is channel k |

## Verification
The assertions assume a legal configuration. Both channel counts must lie between 1 and CH. The configuration may change only right after a clear, when the weight and threshold pointers are both at channel 0. The range checks on the channel pointer and the popcount depend on this. The bench therefore writes the configuration only after a clear strobe, and it drives exactly `cfg_out_ch` thresholds per output word. It sweeps input widths, output widths and shift codes, including a clamped shift. It reloads the input vector halfway through every weight stream and derives each threshold from the modelled accumulator, so that some bits fall exactly on the compare boundary.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
  localparam int unsigned BNN_CH_DEF    = 128;
  localparam int unsigned BNN_ACC_W_DEF = 16;
  localparam int unsigned BNN_THR_W_DEF = 8;

  // Width needed to hold a count from 0 to n inclusive
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Width needed to index n entries
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bnn_popcount.sv
module bnn_popcount #(
  parameter int unsigned N = 128,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0] bits,
  output logic [W-1:0] count
);
  localparam int unsigned LG = (N < 2) ? 1 : $clog2(N);
  localparam int unsigned NP = 1 << LG;

  // Level 0 holds the leaves, level LG the single root
  for (genvar l = 0; l <= LG; l++) begin : g_lvl
    logic [W-1:0] s [NP >> l];
    if (l == 0) begin : g_leaf
      for (genvar g = 0; g < NP; g++) begin : g_bit
        if (g < N) begin : g_real
          assign s[g] = W'(bits[g]);
        end else begin : g_pad
          assign s[g] = '0;
        end
      end
    end else begin : g_node
      for (genvar g = 0; g < (NP >> l); g++) begin : g_add
        assign s[g] = g_lvl[l-1].s[2*g] + g_lvl[l-1].s[2*g+1];
      end
    end
  end

  assign count = g_lvl[LG].s[0];
endmodule

// File: rtl/bnn_acc_bank.sv
module bnn_acc_bank #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rd_q;
  logic [DEPTH-1:0] live;
  logic             rd_live;

  // Plain RAM: registered read, one write port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  // Live flags give a one-cycle bulk clear without touching the RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= '0;
      rd_live <= 1'b0;
    end else begin
      if (clr)        live <= '0;
      else if (wr_en) live[wr_addr] <= 1'b1;
      if (rd_en)      rd_live <= live[rd_addr];
    end
  end

  assign rd_data = rd_live ? rd_q : '0;

  AST_WRITE_NOT_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |-> !wr_en);  // R5
endmodule

// File: rtl/bnn_binarizer.sv
module bnn_binarizer #(
  parameter int unsigned CH    = 128,
  parameter int unsigned ACC_W = 16,
  parameter int unsigned THR_W = 8,
  parameter int unsigned SH_W  = 4,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_out_ch,
  input  logic [SH_W-1:0]  cfg_shift,
  input  logic             thr_fire,
  input  logic [THR_W-1:0] thr_data,
  input  logic [ACC_W-1:0] acc_rd,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [CH-1:0]    out_data
);
  localparam int unsigned MAX_SH = ACC_W - THR_W;

  logic [SH_W-1:0]  eff_sh;
  logic [ACC_W-1:0] thr_sh;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] t_idx;
  logic             t1_vld;
  logic [IDX_W-1:0] t1_idx;
  logic [ACC_W-1:0] t1_thr;
  logic             ov_q;
  logic [CH-1:0]    bits_q;

  always_comb begin
    eff_sh   = (cfg_shift > SH_W'(MAX_SH)) ? SH_W'(MAX_SH) : cfg_shift;
    thr_sh   = ACC_W'(thr_data) << eff_sh;
    last_idx = IDX_W'(cfg_out_ch - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_idx  <= '0;
      t1_vld <= 1'b0;
      t1_idx <= '0;
      t1_thr <= '0;
      ov_q   <= 1'b0;
      bits_q <= '0;
    end else begin
      t1_vld <= thr_fire;
      if (thr_fire) begin
        t1_idx <= t_idx;
        t1_thr <= thr_sh;
        t_idx  <= (t_idx == last_idx) ? '0 : t_idx + IDX_W'(1);
      end
      if (t1_vld) begin
        bits_q[t1_idx] <= (acc_rd >= t1_thr);
        if (t1_idx == last_idx) ov_q <= 1'b1;
      end
      if (ov_q && out_ready) begin
        ov_q   <= 1'b0;
        bits_q <= '0;
      end
    end
  end

  assign rd_idx    = t_idx;
  assign busy      = ov_q | (t1_vld & (t1_idx == last_idx));
  assign out_valid = ov_q;
  assign out_data  = bits_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !out_ready) |=> (ov_q && $stable(bits_q)));  // R9
  AST_NO_THR_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> !thr_fire);  // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> ((bits_q >> cfg_out_ch) == '0));  // R8
endmodule

// File: rtl/bnn_xnor_core.sv
module bnn_xnor_core
  import bnn_pkg::*;
#(
  parameter int unsigned CH    = BNN_CH_DEF,
  parameter int unsigned ACC_W = BNN_ACC_W_DEF,
  parameter int unsigned THR_W = BNN_THR_W_DEF,
  localparam int unsigned CNT_W = cnt_width(CH),
  localparam int unsigned IDX_W = idx_width(CH),
  localparam int unsigned SH_W  = cnt_width(ACC_W - THR_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_in_ch,
  input  logic [CNT_W-1:0] cfg_out_ch,
  input  logic [SH_W-1:0]  cfg_shift,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CH-1:0]    in_data,
  input  logic             w_valid,
  output logic             w_ready,
  input  logic [CH-1:0]    w_data,
  input  logic             acc_clr,
  input  logic             thr_valid,
  output logic             thr_ready,
  input  logic [THR_W-1:0] thr_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CH-1:0]    out_data
);
  logic [CH-1:0]    x_q;
  logic [CH-1:0]    chan_mask;
  logic [CH-1:0]    agree;
  logic [CNT_W-1:0] pc;
  logic             clr_d;
  logic             w_fire, thr_fire;
  logic [IDX_W-1:0] w_idx, last_w, t_idx;
  logic             s1_vld, s1_fwd;
  logic [IDX_W-1:0] s1_idx;
  logic [CNT_W-1:0] s1_pc;
  logic [ACC_W-1:0] s1_fwd_val;
  logic [ACC_W-1:0] acc_rd, base, sum;
  logic [ACC_W:0]   ext;
  logic             rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic             bin_busy;

  // Stationary input vector
  always_ff @(posedge clk) begin
    if (rst)           x_q <= '0;
    else if (in_valid) x_q <= in_data;
  end
  assign in_ready = 1'b1;

  for (genvar g = 0; g < CH; g++) begin : g_mask
    assign chan_mask[g] = (CNT_W'(g) < cfg_in_ch);
  end

  assign agree = ~(w_data ^ x_q) & chan_mask;

  bnn_popcount #(.N(CH), .W(CNT_W)) u_pc (
    .bits  (agree),
    .count (pc)
  );

  // Handshakes: a clear blocks weights for two cycles; thresholds wait
  // until no weight is pending or in flight
  assign w_ready   = ~(acc_clr | clr_d);
  assign w_fire    = w_valid & w_ready;
  assign thr_ready = ~(acc_clr | clr_d | w_valid | s1_vld | bin_busy);
  assign thr_fire  = thr_valid & thr_ready;
  assign last_w    = IDX_W'(cfg_out_ch - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_d      <= 1'b0;
      w_idx      <= '0;
      s1_vld     <= 1'b0;
      s1_fwd     <= 1'b0;
      s1_idx     <= '0;
      s1_pc      <= '0;
      s1_fwd_val <= '0;
    end else begin
      clr_d  <= acc_clr;
      s1_vld <= w_fire;
      s1_fwd <= w_fire & s1_vld & (s1_idx == w_idx);
      if (w_fire) begin
        s1_idx     <= w_idx;
        s1_pc      <= pc;
        s1_fwd_val <= sum;
      end
      if (acc_clr)     w_idx <= '0;
      else if (w_fire) w_idx <= (w_idx == last_w) ? '0 : w_idx + IDX_W'(1);
    end
  end

  // Accumulate stage: forwarded value covers a write landing on the read edge
  always_comb begin
    base = s1_fwd ? s1_fwd_val : acc_rd;
    ext  = {1'b0, base} + (ACC_W+1)'(s1_pc);
    sum  = ext[ACC_W] ? {ACC_W{1'b1}} : ext[ACC_W-1:0];
  end

  assign rd_en   = w_fire | thr_fire;
  assign rd_addr = w_fire ? w_idx : t_idx;

  bnn_acc_bank #(.DEPTH(CH), .AW(IDX_W), .DW(ACC_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_d),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (acc_rd),
    .wr_en   (s1_vld),
    .wr_addr (s1_idx),
    .wr_data (sum)
  );

  bnn_binarizer #(
    .CH(CH), .ACC_W(ACC_W), .THR_W(THR_W),
    .SH_W(SH_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_bin (
    .clk        (clk),
    .rst        (rst),
    .cfg_out_ch (cfg_out_ch),
    .cfg_shift  (cfg_shift),
    .thr_fire   (thr_fire),
    .thr_data   (thr_data),
    .acc_rd     (acc_rd),
    .rd_idx     (t_idx),
    .busy       (bin_busy),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  AST_CLR_STALL: assert property (@(posedge clk) disable iff (rst)
    acc_clr |-> !w_ready);  // R5
  AST_READ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(w_fire && thr_fire));  // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> (sum >= base));  // R6
  AST_PC_RANGE: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> (s1_pc <= cfg_in_ch));  // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(w_idx) < cfg_out_ch);  // R4
endmodule

// File: tb/tb_bnn_xnor_core.sv
module tb_bnn_xnor_core;
  localparam int CH    = 16;
  localparam int ACC_W = 16;
  localparam int THR_W = 8;
  localparam int CNT_W = 5;
  localparam int SH_W  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cfg_in_ch = CNT_W'(CH);
  logic [CNT_W-1:0] cfg_out_ch = CNT_W'(CH);
  logic [SH_W-1:0]  cfg_shift = '0;
  logic             in_valid = 1'b0, in_ready;
  logic [CH-1:0]    in_data = '0;
  logic             w_valid = 1'b0, w_ready;
  logic [CH-1:0]    w_data = '0;
  logic             acc_clr = 1'b0;
  logic             thr_valid = 1'b0, thr_ready;
  logic [THR_W-1:0] thr_data = '0;
  logic             out_valid, out_ready = 1'b0;
  logic [CH-1:0]    out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  bnn_xnor_core #(.CH(CH), .ACC_W(ACC_W), .THR_W(THR_W)) dut (
    .clk(clk), .rst(rst),
    .cfg_in_ch(cfg_in_ch), .cfg_out_ch(cfg_out_ch), .cfg_shift(cfg_shift),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .acc_clr(acc_clr),
    .thr_valid(thr_valid), .thr_ready(thr_ready), .thr_data(thr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [CH-1:0] act, input logic [CH-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int agree_cnt(input logic [CH-1:0] w, input logic [CH-1:0] x,
                                   input int inch);
    int c = 0;
    for (int i = 0; i < inch; i++) if (w[i] == x[i]) c++;
    return c;
  endfunction

  task automatic do_clr();
    @(negedge clk); acc_clr = 1'b1;
    #1 chk(w_ready == 1'b0, "R5 stall on clear", CH'(w_ready), '0);
    @(negedge clk); acc_clr = 1'b0;
    #1 chk(w_ready == 1'b0, "R5 stall after clear", CH'(w_ready), '0);
    @(negedge clk);
  endtask

  task automatic run_layer(input int inch, input int outch, input int sh,
                           input int reps, input bit same, input bit hold,
                           input string tag);
    int            acc [CH];
    int            thr [CH];
    int            esh, n, half, t, wait_n;
    logic [CH-1:0] xcur, xnew, w, expv, snap;
    do_clr();
    cfg_in_ch = CNT_W'(inch); cfg_out_ch = CNT_W'(outch); cfg_shift = SH_W'(sh);
    // junk words move the pointer; the next clear must discard them
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      w_valid = 1'b1; w_data = CH'($urandom);
      @(negedge clk);
    end
    w_valid = 1'b0;
    do_clr();
    for (int k = 0; k < CH; k++) acc[k] = 0;
    xcur = CH'($urandom);
    in_valid = 1'b1; in_data = xcur;
    @(negedge clk); in_valid = 1'b0;
    n = outch * reps; half = n / 2;
    for (int j = 0; j < n; j++) begin
      w = same ? xcur : CH'($urandom);
      w_valid = 1'b1; w_data = w;
      if (j == half) begin
        xnew = CH'($urandom);
        in_valid = 1'b1; in_data = xnew;
      end
      acc[j % outch] += agree_cnt(w, xcur, inch);
      if (acc[j % outch] > 65535) acc[j % outch] = 65535;
      while (!w_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (j == half) xcur = xnew;
    end
    w_valid = 1'b0;
    esh = (sh > 8) ? 8 : sh;
    expv = '0;
    for (int k = 0; k < outch; k++) begin
      t = (acc[k] >> esh) + (k % 3) - 1;
      if (t < 0) t = 0;
      if (t > 255) t = 255;
      thr[k] = t;
      if (acc[k] >= (t << esh)) expv[k] = 1'b1;
    end
    for (int k = 0; k < outch; k++) begin
      thr_valid = 1'b1; thr_data = THR_W'(thr[k]);
      while (!thr_ready) @(negedge clk);
      @(negedge clk);
    end
    thr_valid = 1'b0;
    wait_n = 0;
    while (!out_valid && wait_n < 50) begin
      @(negedge clk); wait_n++;
    end
    chk(out_valid == 1'b1, {tag, " output valid"}, CH'(out_valid), CH'(1));
    chk(out_data == expv, {tag, " output word"}, out_data, expv);
    if (outch < CH)
      chk((out_data >> outch) == '0, "R8 unused bits zero", out_data >> outch, '0);
    if (hold) begin
      snap = out_data;
      thr_valid = 1'b1; thr_data = '0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk(out_valid == 1'b1, "R9 valid held", CH'(out_valid), CH'(1));
        chk(out_data == snap, "R9 data held", out_data, snap);
        chk(thr_ready == 1'b0, "R9 threshold blocked", CH'(thr_ready), '0);
      end
      thr_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    chk(out_valid == 1'b0, "R9 valid drops after handshake", CH'(out_valid), '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid", CH'(out_valid), '0);
    chk(out_data == '0, "R11 out_data", out_data, '0);
    chk(in_ready == 1'b1, "R11 in_ready", CH'(in_ready), CH'(1));
    chk(w_ready == 1'b1, "R11 w_ready", CH'(w_ready), CH'(1));
    chk(thr_ready == 1'b1, "R11 thr_ready", CH'(thr_ready), CH'(1));
    // R5: after a clear all accumulators are zero
    run_layer(CH, CH, 0, 0, 1'b0, 1'b0, "R5 cleared bank");
    // Sweep: R1 R2 R3 R4 R7 R8 R10
    foreach (int_list_dummy[i]) ;
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int s = 0; s < 4; s++) begin
          int inch, outch, sh;
          inch  = (a == 0) ? 1 : (a == 1) ? 5 : CH;
          outch = (b == 0) ? 1 : (b == 1) ? 7 : CH;
          sh    = (s == 0) ? 0 : (s == 1) ? 3 : (s == 2) ? 8 : 11;
          run_layer(inch, outch, sh, 3, 1'b0, 1'b0, "R1 R2 R3 R4 R7 R8 R10");
        end
      end
    end
    run_layer(CH, 7, 2, 2, 1'b0, 1'b1, "R9 hold");
    run_layer(CH, 1, 8, 4100, 1'b1, 1'b0, "R6 saturation");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int int_list_dummy [1];
endmodule